// File: doc/BRIEF.md
# Real-time clock with alarm

This block is a register-mapped seconds clock. It runs on the slow oscillator clock (nominally 32.768 kHz). A prescaler with a programmable divide value and a trim correction turns that clock into a one-per-second tick. Each tick advances a 32-bit seconds count. The count is compared against a 32-bit alarm value. Software reads and writes four registers over a simple single-cycle bus: write strobe, byte address and write data, with combinational read data.

A status word holds two interrupt enables and two sticky event flags. One flag marks a tick and the other marks an alarm match. Software clears a flag by writing a one to its bit. Two level interrupt lines, one for the tick and one for the alarm, show each flag masked by its enable. If the divide/trim register is left at zero, the prescaler falls back to a default divide value, so the count still advances once per second from a 32.768 kHz source.

Top module: `rtc_core`

## Requirements
- R1: After reset, every register reads zero and both interrupt outputs are low.
- R2: The divide/trim register at offset 0x08 holds the divide value D in bits 15:0. With zero trim, the seconds count advances once every D+1 clocks. While the whole register is zero, D is taken as 32767, so the period is 32768 clocks.
- R3: Bits 31:16 of the divide/trim register hold a trim count N. When N is nonzero, every N-th tick period is one clock shorter (D clocks), counting from the last write to the seconds count.
- R4: The seconds count at offset 0x04 reads back what was written. A write restarts the prescaler, so the first increment lands D+1 clocks after the write edge. The count wraps from 0xFFFFFFFF to 0.
- R5: The status register is at offset 0x10. Status bit 1 (tick flag) is set on every tick, whatever the value of its enable in bit 3.
- R6: The alarm register is at offset 0x00. Status bit 0 (alarm flag) is set when a tick makes the seconds count equal to the alarm value, including a wrap to 0.
- R7: Status bits 3 (tick enable) and 2 (alarm enable) are read/write. Writing 1 to bit 1 or bit 0 clears that flag, and writing 0 leaves it unchanged.
- R8: When a flag is set and cleared in the same cycle, it ends up set.
- R9: irq_tick equals status bit 1 AND bit 3, and irq_alarm equals status bit 0 AND bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, also used by the register bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_tick | output | 1 | Tick interrupt level |
| irq_alarm | output | 1 | Alarm interrupt level |

## Verification
The hardest case to reach is a write-one-to-clear that lands on the exact edge where a tick sets the same flag. The bench gets there by writing the seconds count, which puts the prescaler phase at a known point. It then uses a short divide value and idles a counted number of cycles, so the clearing write coincides with the tick edge. Trim periods are checked the same way: the bench times successive count changes after a counter write and compares the sequence of long and short periods with the trim count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int unsigned REG_AW   = 5;
   localparam int unsigned BUS_W    = 32;
   localparam logic [REG_AW-1:0] OFS_ALARM   = 5'h00;
   localparam logic [REG_AW-1:0] OFS_SECONDS = 5'h04;
   localparam logic [REG_AW-1:0] OFS_DIVTRIM = 5'h08;
   localparam logic [REG_AW-1:0] OFS_STATUS  = 5'h10;
   localparam int unsigned ST_TICK_EN  = 3;
   localparam int unsigned ST_ALM_EN   = 2;
   localparam int unsigned ST_TICK_EVT = 1;
   localparam int unsigned ST_ALM_EVT  = 0;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned TRIM_W      = 16,
   parameter bit          TRIM_EN     = 1'b1,
   parameter int unsigned DEFAULT_DIV = 32767
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    restart,
   input  logic [DIV_W+TRIM_W-1:0] div_trim,
   output logic                    tick
);
   localparam int unsigned CFG_W = DIV_W + TRIM_W;

   if (DIV_W < 2) begin : g_chk_div
      $error("rtc_prescaler: DIV_W must be at least 2");
   end
   if (DEFAULT_DIV >= (1 << DIV_W)) begin : g_chk_def
      $error("rtc_prescaler: DEFAULT_DIV does not fit in DIV_W");
   end

   logic [DIV_W-1:0]  div_eff;
   logic [DIV_W-1:0]  limit;
   logic [DIV_W-1:0]  phase;
   logic              short_period;

   assign div_eff = (div_trim == '0) ? DEFAULT_DIV[DIV_W-1:0] : div_trim[DIV_W-1:0];

   if (TRIM_EN) begin : g_trim
      logic [TRIM_W-1:0] trim_n;
      logic [TRIM_W-1:0] per_idx;
      assign trim_n = div_trim[CFG_W-1:DIV_W];
      assign short_period = (trim_n != '0) && (div_eff != '0) &&
                            (per_idx == trim_n - 1'b1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            per_idx <= '0;
         end else if (restart) begin
            per_idx <= '0;
         end else if (tick) begin
            if (trim_n == '0 || per_idx >= trim_n - 1'b1) per_idx <= '0;
            else                                          per_idx <= per_idx + 1'b1;
         end
      end
   end else begin : g_no_trim
      assign short_period = 1'b0;
   end

   assign limit = short_period ? div_eff - 1'b1 : div_eff;
   assign tick  = (phase >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase <= '0;
      else if (restart) phase <= '0;
      else if (tick)    phase <= '0;
      else              phase <= phase + 1'b1;
   end

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (phase == '0)); // R4
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] alarm_val,
   output logic [CNT_W-1:0] count,
   output logic             alarm_hit
);
   if (CNT_W < 2) begin : g_chk_w
      $error("rtc_seconds: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] count_inc;
   assign count_inc = count + 1'b1;
   assign alarm_hit = tick && !load && (count_inc == alarm_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (load) count <= load_val;
      else if (tick) count <= count_inc;
   end

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && count != $past(count)) |-> (count == $past(count) + 1'b1)); // R4
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && count == '1) |=> (count == '0)); // R4
   AST_ALARM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |=> (count == $past(alarm_val))); // R6
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
   import rtc_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned TRIM_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_we,
   input  logic [REG_AW-1:0]       reg_addr,
   input  logic [BUS_W-1:0]        reg_wdata,
   output logic [BUS_W-1:0]        reg_rdata,
   input  logic [CNT_W-1:0]        count,
   input  logic                    tick,
   input  logic                    alarm_hit,
   output logic                    count_we,
   output logic [CNT_W-1:0]        alarm_q,
   output logic [DIV_W+TRIM_W-1:0] divtrim_q,
   output logic                    irq_tick,
   output logic                    irq_alarm
);
   if (CNT_W > BUS_W || DIV_W + TRIM_W > BUS_W) begin : g_chk_fit
      $error("rtc_regs: register fields exceed bus width");
   end

   logic tick_en, alm_en, tick_evt, alm_evt;
   logic st_we, clr_tick, clr_alm;

   assign count_we = reg_we && (reg_addr == OFS_SECONDS);
   assign st_we    = reg_we && (reg_addr == OFS_STATUS);
   assign clr_tick = st_we && reg_wdata[ST_TICK_EVT];
   assign clr_alm  = st_we && reg_wdata[ST_ALM_EVT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_q   <= '0;
         divtrim_q <= '0;
         tick_en   <= 1'b0;
         alm_en    <= 1'b0;
         tick_evt  <= 1'b0;
         alm_evt   <= 1'b0;
      end else begin
         if (reg_we && reg_addr == OFS_ALARM)   alarm_q   <= reg_wdata[CNT_W-1:0];
         if (reg_we && reg_addr == OFS_DIVTRIM) divtrim_q <= reg_wdata[DIV_W+TRIM_W-1:0];
         if (st_we) begin
            tick_en <= reg_wdata[ST_TICK_EN];
            alm_en  <= reg_wdata[ST_ALM_EN];
         end
         tick_evt <= tick || (tick_evt && !clr_tick);
         alm_evt  <= alarm_hit || (alm_evt && !clr_alm);
      end
   end

   assign irq_tick  = tick_evt && tick_en;
   assign irq_alarm = alm_evt && alm_en;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_ALARM:   reg_rdata[CNT_W-1:0]       = alarm_q;
         OFS_SECONDS: reg_rdata[CNT_W-1:0]       = count;
         OFS_DIVTRIM: reg_rdata[DIV_W+TRIM_W-1:0] = divtrim_q;
         OFS_STATUS: begin
            reg_rdata[ST_TICK_EN]  = tick_en;
            reg_rdata[ST_ALM_EN]   = alm_en;
            reg_rdata[ST_TICK_EVT] = tick_evt;
            reg_rdata[ST_ALM_EVT]  = alm_evt;
         end
         default: reg_rdata = '0;
      endcase
   end

   AST_TICK_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tick_evt) |-> $past(tick)); // R5
   AST_TICK_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> tick_evt); // R8
   AST_ALARM_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |=> alm_evt); // R8
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en |-> !irq_tick) and (!alm_en |-> !irq_alarm)); // R9
endmodule

// File: rtl/rtc_core.sv
module rtc_core
   import rtc_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned TRIM_W      = 16,
   parameter bit          TRIM_EN     = 1'b1,
   parameter int unsigned DEFAULT_DIV = 32767
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   output logic              irq_tick,
   output logic              irq_alarm
);
   localparam int unsigned CFG_W = DIV_W + TRIM_W;

   logic             tick, count_we, alarm_hit;
   logic [CNT_W-1:0] count, alarm_q;
   logic [CFG_W-1:0] divtrim_q;

   rtc_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .TRIM_W(TRIM_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count(count), .tick(tick),
      .alarm_hit(alarm_hit), .count_we(count_we), .alarm_q(alarm_q),
      .divtrim_q(divtrim_q), .irq_tick(irq_tick), .irq_alarm(irq_alarm)
   );

   rtc_prescaler #(.DIV_W(DIV_W), .TRIM_W(TRIM_W), .TRIM_EN(TRIM_EN),
                   .DEFAULT_DIV(DEFAULT_DIV)) presc_i (
      .clk(clk), .rst_n(rst_n), .restart(count_we), .div_trim(divtrim_q), .tick(tick)
   );

   rtc_seconds #(.CNT_W(CNT_W)) secs_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(count_we),
      .load_val(reg_wdata[CNT_W-1:0]), .alarm_val(alarm_q),
      .count(count), .alarm_hit(alarm_hit)
   );
endmodule

// File: tb/rtc_core_tb.sv
module rtc_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_tick, irq_alarm;
   int          n_chk = 0;
   int          n_err = 0;

   localparam logic [4:0] A_ALM = 5'h00, A_CNT = 5'h04, A_DIV = 5'h08, A_ST = 5'h10;

   always #5 clk = ~clk;

   rtc_core dut_i (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
                   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
                   .irq_tick(irq_tick), .irq_alarm(irq_alarm));

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1 reg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic measure(output int n);
      logic [31:0] prev, cur;
      rd(A_CNT, prev);
      n = 0;
      do begin
         @(posedge clk); #1;
         n++;
         rd(A_CNT, cur);
      end while (cur == prev && n < 40000);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_ALM, v); check(v == 0, "R1 alarm", v, 0);
      rd(A_CNT, v); check(v == 0, "R1 count", v, 0);
      rd(A_DIV, v); check(v == 0, "R1 divtrim", v, 0);
      rd(A_ST, v);  check(v == 0, "R1 status", v, 0);
      check(!irq_tick && !irq_alarm, "R1 irqs", {irq_tick, irq_alarm}, 0);
   endtask

   task automatic t_default_rate();
      int n;
      wr(A_CNT, 32'd0);
      measure(n);
      check(n == 32768, "R2 default period", n, 32768);
   endtask

   task automatic t_divider();
      int n;
      logic [31:0] v;
      wr(A_DIV, 32'h0000_0009);
      wr(A_CNT, 32'd100);
      rd(A_CNT, v); check(v == 100, "R4 count readback", v, 100);
      measure(n); check(n == 10, "R4 first period after write", n, 10);
      measure(n); check(n == 10, "R2 period D+1", n, 10);
      rd(A_CNT, v); check(v == 102, "R2 count value", v, 102);
   endtask

   task automatic t_trim();
      int n;
      wr(A_DIV, 32'h0003_0009);
      wr(A_CNT, 32'd0);
      measure(n); check(n == 10, "R3 trim period 1", n, 10);
      measure(n); check(n == 10, "R3 trim period 2", n, 10);
      measure(n); check(n == 9,  "R3 trim short period 3", n, 9);
      measure(n); check(n == 10, "R3 trim period 4", n, 10);
   endtask

   task automatic t_flags();
      logic [31:0] v;
      int n;
      wr(A_DIV, 32'h0000_0003);
      wr(A_ST, 32'h0000_0003);
      measure(n);
      rd(A_ST, v); check(v[1] == 1'b1, "R5 tick flag with enable off", v, 32'h2);
      check(!irq_tick, "R9 irq_tick masked", irq_tick, 0);
      wr(A_ST, 32'h0000_0008);
      rd(A_ST, v); check(v[3:1] == 3'b101, "R7 enable set, zero write keeps flag", v, 32'ha);
      check(irq_tick, "R9 irq_tick enabled", irq_tick, 1);
      wr(A_ST, 32'h0000_000A);
      rd(A_ST, v); check(v[1] == 1'b0, "R7 write-one clears tick flag", v, 32'h8);
      check(!irq_tick, "R9 irq_tick after clear", irq_tick, 0);
      wr(A_ST, 32'h0000_0000);
   endtask

   task automatic t_alarm();
      logic [31:0] v;
      int n;
      wr(A_DIV, 32'h0000_0003);
      wr(A_ALM, 32'd6);
      wr(A_CNT, 32'd4);
      wr(A_ST, 32'h0000_0007);
      measure(n);
      rd(A_ST, v); check(v[0] == 1'b0, "R6 no alarm before match", v, 32'h6);
      measure(n);
      rd(A_CNT, v); check(v == 6, "R6 count at alarm", v, 6);
      rd(A_ST, v); check(v[0] == 1'b1, "R6 alarm flag on match", v, 32'h7);
      check(irq_alarm, "R9 irq_alarm enabled", irq_alarm, 1);
      wr(A_ST, 32'h0000_0001);
      rd(A_ST, v); check(v[2] == 1'b0 && v[0] == 1'b0, "R7 alarm clear and disable", v, 0);
      check(!irq_alarm, "R9 irq_alarm off", irq_alarm, 0);
      wr(A_ALM, 32'd0);
      wr(A_CNT, 32'hFFFF_FFFF);
      wr(A_ST, 32'h0000_0004);
      measure(n);
      rd(A_CNT, v); check(v == 0, "R4 wrap to zero", v, 0);
      rd(A_ST, v); check(v[0] == 1'b1, "R6 alarm on wrap", v, 32'h5);
      check(irq_alarm, "R9 irq_alarm on wrap", irq_alarm, 1);
   endtask

   task automatic t_set_wins();
      logic [31:0] v;
      wr(A_DIV, 32'h0000_0002);
      wr(A_CNT, 32'd50);
      wr(A_ST, 32'h0000_0002);
      rd(A_ST, v); check(v[1] == 1'b0, "R7 clear away from tick", v, 0);
      @(posedge clk);
      wr(A_ST, 32'h0000_0002);
      rd(A_CNT, v); check(v == 51, "R8 tick on clearing edge", v, 51);
      rd(A_ST, v); check(v[1] == 1'b1, "R8 set wins over clear", v, 32'h2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_default_rate();
      t_divider();
      t_trim();
      t_flags();
      t_alarm();
      t_set_wins();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule